// File: doc/BRIEF.md
# Frame Pulse Format Detector and Converter

This block sits at the framing edge of a small time-slot switch. It receives an 8 kHz frame pulse that may arrive in either of two formats. The first is an active-low pulse that straddles the frame boundary. The second is an active-high pulse at the start of slot 5. The block works out which format is present by watching the level the input rests at. It then keeps a timebase aligned to the pulse and drives the slot count, the bit count and a frame-start strobe to the switch core. It also regenerates the pulse in the other format, so that equipment on either side of the switch can share one frame reference.

The timebase assumes a clock at twice the 2.048 Mb/s bit rate, which gives two clocks per bit, eight bits per slot and 32 slots per frame. The frame is 512 clocks long. A frame position p, counted from 0 to 511, is split as follows: the phase within the bit is p[0], the bit index is p[3:1] and the slot is p[8:4]. All counts are parameters and must be powers of two.

Top module: `fpc_frame_conv`

## Requirements
- R1: While reset is asserted, slot_o is 0, bit_o is 0, frame_start_o is 1 and fp_o is 0. The format register starts as active-low, and no format is yet confirmed.
- R2: Unless a resynchronisation occurs, the frame position advances by one every clock and wraps from 511 to 0. frame_start_o is 1 exactly at position 0.
- R3: The format changes only after five consecutive equal samples of fp_i. Five highs select the active-low format, and five lows select the active-high format. Four equal samples leave the format unchanged.
- R4: With the active-low format confirmed, a sample of 0 that follows a sample of 1 resynchronises the timebase. In the next clock the position is 0, meaning slot 0, bit 0 and frame_start_o at 1. If the timebase was already aligned, this matches the natural wrap.
- R5: With the active-high format confirmed, a sample of 1 that follows a sample of 0 resynchronises the timebase. In the next clock the position is 81, meaning slot 5, bit 0 and phase 1.
- R6: Until a format has been confirmed since reset, transitions on fp_i never resynchronise the timebase.
- R7: With the active-low format confirmed, fp_o is 1 only at positions 80 and 81 (one bit from the start of slot 5) and is 0 elsewhere. Before any format is confirmed, fp_o rests at 0 in this format.
- R8: With the active-high format confirmed, fp_o is 0 only at positions 511 and 0 (one bit centred on the frame boundary) and is 1 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, two periods per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Incoming frame pulse, either format |
| fp_o | output | 1 | Regenerated pulse in the opposite format |
| slot_o | output | 5 | Current slot number |
| bit_o | output | 3 | Bit index within the slot |
| frame_start_o | output | 1 | High in the first clock of a frame |

## Verification
Two functions can fall in the same cycle: a resynchronisation load and the free-running increment with its wrap. The bench applies pulses both in phase, where the load and the increment agree (position 511 for the active-low format, 80 for the active-high format), and out of phase at arbitrary positions, where the load must override the increment. A behavioural model, built from integer positions, predicts the slot, the bit, the strobe and the converted pulse on every clock. Directed checks confirm the landing position named by R4 and R5 in the clock after each pulse.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  // Which polarity the incoming pulse uses; the output uses the other one.
  typedef enum logic {
    FP_ACT_HIGH = 1'b0,
    FP_ACT_LOW  = 1'b1
  } fp_fmt_e;
endpackage

// File: rtl/fpc_fmt_detect.sv
module fpc_fmt_detect
  import fpc_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fp_i,
  output fp_fmt_e fmt_o,
  output logic    vld_o,
  output logic    sync_o
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(RUN_LEN);
  localparam logic [RW-1:0] RUN_ONE = RW'(1);

  logic          prev_q, prev_d;
  logic [RW-1:0] run_q, run_d;
  fp_fmt_e       fmt_q, fmt_d;
  logic          vld_q, vld_d;

  always_comb begin
    prev_d = fp_i;
    if (fp_i != prev_q)       run_d = RUN_ONE;
    else if (run_q < RUN_MAX) run_d = run_q + RUN_ONE;
    else                      run_d = run_q;
    fmt_d = fmt_q;
    vld_d = vld_q;
    if (run_d == RUN_MAX) begin
      fmt_d = fp_i ? FP_ACT_LOW : FP_ACT_HIGH;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      run_q  <= '0;
      fmt_q  <= FP_ACT_LOW;
      vld_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      run_q  <= run_d;
      fmt_q  <= fmt_d;
      vld_q  <= vld_d;
    end
  end

  // Leading edge of an active pulse under the confirmed format.
  assign sync_o = vld_q && ((fmt_q == FP_ACT_LOW) ? (prev_q && !fp_i)
                                                  : (!prev_q && fp_i));
  assign fmt_o = fmt_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/fpc_timebase.sv
module fpc_timebase
  import fpc_pkg::*;
#(
  parameter int CW        = 9,
  parameter int LOAD_LOW  = 0,
  parameter int LOAD_HIGH = 81
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  fp_fmt_e       fmt_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LD_LO = CW'(LOAD_LOW);
  localparam logic [CW-1:0] LD_HI = CW'(LOAD_HIGH);
  localparam logic [CW-1:0] STEP  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (sync_i) cnt_d = (fmt_i == FP_ACT_LOW) ? LD_LO : LD_HI;
    else        cnt_d = cnt_q + STEP;   // natural wrap at a power-of-two frame
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fpc_pulse_gen.sv
module fpc_pulse_gen
  import fpc_pkg::*;
#(
  parameter int CW       = 9,
  parameter int HI_POS   = 80,
  parameter int BIT_CLKS = 2
) (
  input  logic [CW-1:0] cnt_i,
  input  fp_fmt_e       fmt_i,
  input  logic          vld_i,
  output logic          fp_o
);
  localparam int FRAME = 1 << CW;
  localparam int HALF  = (BIT_CLKS > 1) ? BIT_CLKS / 2 : 1;
  localparam logic [CW-1:0] HI_A = CW'(HI_POS);
  localparam logic [CW-1:0] HI_B = CW'(HI_POS + BIT_CLKS);
  localparam logic [CW-1:0] LO_A = CW'(FRAME - HALF);
  localparam logic [CW-1:0] LO_B = CW'(HALF);

  logic in_hi_win, in_lo_win;

  assign in_hi_win = (cnt_i >= HI_A) && (cnt_i < HI_B);
  assign in_lo_win = (cnt_i >= LO_A) || (cnt_i < LO_B);

  always_comb begin
    if (fmt_i == FP_ACT_LOW) fp_o = vld_i && in_hi_win;     // emit active-high
    else                     fp_o = !(vld_i && in_lo_win);  // emit active-low
  end
endmodule

// File: rtl/fpc_frame_conv.sv
module fpc_frame_conv
  import fpc_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int BITS     = 8,
  parameter int BIT_CLKS = 2,
  parameter int RUN_LEN  = 5,
  parameter int HI_SLOT  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fp_i,
  output logic                     fp_o,
  output logic [$clog2(SLOTS)-1:0] slot_o,
  output logic [$clog2(BITS)-1:0]  bit_o,
  output logic                     frame_start_o
);
  localparam int TS_W      = $clog2(SLOTS);
  localparam int BIT_W     = $clog2(BITS);
  localparam int PH_W      = $clog2(BIT_CLKS);
  localparam int CW        = TS_W + BIT_W + PH_W;
  localparam int FRAME     = SLOTS * BITS * BIT_CLKS;
  localparam int SLOT_CLKS = BITS * BIT_CLKS;
  localparam int HI_POS    = HI_SLOT * SLOT_CLKS;
  localparam int HALF      = (BIT_CLKS > 1) ? BIT_CLKS / 2 : 1;
  // The first active sample lands one clock before these loads take effect.
  localparam int LOAD_LOW  = (FRAME - HALF + 1) % FRAME;
  localparam int LOAD_HIGH = (HI_POS + 1) % FRAME;

  fp_fmt_e       fmt;
  logic          fmt_vld;
  logic          sync_ld;
  logic [CW-1:0] cnt;

  fpc_fmt_detect #(.RUN_LEN(RUN_LEN)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .fp_i   (fp_i),
    .fmt_o  (fmt),
    .vld_o  (fmt_vld),
    .sync_o (sync_ld)
  );

  fpc_timebase #(.CW(CW), .LOAD_LOW(LOAD_LOW), .LOAD_HIGH(LOAD_HIGH)) u_tbase (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_ld),
    .fmt_i  (fmt),
    .cnt_o  (cnt)
  );

  fpc_pulse_gen #(.CW(CW), .HI_POS(HI_POS), .BIT_CLKS(BIT_CLKS)) u_pgen (
    .cnt_i (cnt),
    .fmt_i (fmt),
    .vld_i (fmt_vld),
    .fp_o  (fp_o)
  );

  assign slot_o        = cnt[CW-1 -: TS_W];
  assign bit_o         = cnt[PH_W +: BIT_W];
  assign frame_start_o = (cnt == '0);
endmodule

// File: rtl/fpc_frame_conv_chk.sv
module fpc_frame_conv_chk
  import fpc_pkg::*;
#(
  parameter int TS_W    = 5,
  parameter int BIT_W   = 3,
  parameter int HI_SLOT = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fp_i,
  input logic             fp_o,
  input logic [TS_W-1:0]  slot_o,
  input logic [BIT_W-1:0] bit_o,
  input logic             frame_start_o,
  input fp_fmt_e          fmt,
  input logic             fmt_vld,
  input logic             sync_ld
);
  localparam logic [TS_W-1:0]  S_HI   = TS_W'(HI_SLOT);
  localparam logic [TS_W-1:0]  S_LAST = '1;
  localparam logic [BIT_W-1:0] B_LAST = '1;

  a_r2_frame_mark: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (slot_o == '0 && bit_o == '0));

  a_r2_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ld |=> (bit_o == $past(bit_o) || bit_o == $past(bit_o) + 1'b1));

  a_r3_flip_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt != $past(fmt)) |-> ($past(fp_i) == $past(fp_i, 2)));

  a_r4_low_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ld && fmt == FP_ACT_LOW) |=> frame_start_o);

  a_r5_high_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ld && fmt == FP_ACT_HIGH) |=> (slot_o == S_HI && bit_o == '0));

  a_r6_no_unlocked_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_vld |-> !sync_ld);

  a_r7_high_out_window: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_vld && fmt == FP_ACT_LOW && fp_o) |-> (slot_o == S_HI && bit_o == '0));

  a_r8_low_out_window: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_vld && fmt == FP_ACT_HIGH && !fp_o) |->
      ((slot_o == '0 && bit_o == '0) || (slot_o == S_LAST && bit_o == B_LAST)));
endmodule

bind fpc_frame_conv fpc_frame_conv_chk #(
  .TS_W(TS_W), .BIT_W(BIT_W), .HI_SLOT(HI_SLOT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fp_i          (fp_i),
  .fp_o          (fp_o),
  .slot_o        (slot_o),
  .bit_o         (bit_o),
  .frame_start_o (frame_start_o),
  .fmt           (fmt),
  .fmt_vld       (fmt_vld),
  .sync_ld       (sync_ld)
);

// File: tb/fpc_frame_conv_tb.sv
module fpc_frame_conv_tb;
  logic       clk;
  logic       rst_n;
  logic       fp_in;
  logic       fp_o;
  logic [4:0] slot_o;
  logic [2:0] bit_o;
  logic       frame_start_o;

  int vectors;
  int miscompares;
  bit done;

  // Behavioural reference state
  int m_cnt;
  int m_run;
  bit m_low;
  bit m_vld;
  bit m_prev;

  fpc_frame_conv u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .fp_i          (fp_in),
    .fp_o          (fp_o),
    .slot_o        (slot_o),
    .bit_o         (bit_o),
    .frame_start_o (frame_start_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_low = 1'b1; m_vld = 1'b0; m_prev = 1'b1;
    end else begin
      bit fp;
      bit hit;
      int nxt;
      fp  = fp_in;
      hit = m_vld && (m_low ? (m_prev && !fp) : (!m_prev && fp));
      nxt = hit ? (m_low ? 0 : 81) : (m_cnt + 1) % 512;
      if (fp == m_prev) m_run = (m_run < 5) ? m_run + 1 : 5;
      else              m_run = 1;
      if (m_run == 5) begin m_low = fp; m_vld = 1'b1; end
      m_prev = fp;
      m_cnt  = nxt;
    end
  end

  function automatic bit exp_fp();
    if (!m_vld) return !m_low;
    if (m_low)  return (m_cnt == 80 || m_cnt == 81);
    return !(m_cnt == 511 || m_cnt == 0);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Every-clock comparison against the model (R2 timebase, R7/R8 output).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(slot_o == 5'((m_cnt >> 4) & 31), "R2 slot", slot_o, (m_cnt >> 4) & 31);
      chk(bit_o == 3'((m_cnt >> 1) & 7), "R2 bit", bit_o, (m_cnt >> 1) & 7);
      chk(frame_start_o == (m_cnt == 0), "R2 frame_start", frame_start_o, m_cnt == 0);
      chk(fp_o == exp_fp(), "R7/R8 fp_o", fp_o, exp_fp());
    end
  end

  task automatic wait_pos(input int p);
    do @(negedge clk); while (m_cnt != p);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    vectors = 0; miscompares = 0; done = 1'b0;
    rst_n = 1'b0; fp_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(slot_o == 0, "R1 slot", slot_o, 0);
    chk(bit_o == 0, "R1 bit", bit_o, 0);
    chk(frame_start_o == 1, "R1 frame_start", frame_start_o, 1);
    chk(fp_o == 0, "R1 fp_o", fp_o, 0);
    rst_n = 1'b1;
    @(negedge clk);            // position 1
    fp_in = 1'b0;              // falling edge before any format is confirmed
    @(negedge clk);
    // R6: no load, position 2
    chk(slot_o == 0 && bit_o == 1 && !frame_start_o, "R6 no unlocked sync", bit_o, 1);
    fp_in = 1'b1;
    // Five highs confirm the active-low format (R3), then an output pulse (R7)
    wait_pos(80);
    chk(fp_o == 1, "R7 pulse at slot 5", fp_o, 1);
    wait_pos(82);
    chk(fp_o == 0, "R7 pulse ends", fp_o, 0);
    // R4: out-of-phase falling edge overrides the increment
    wait_pos(200);
    fp_in = 1'b0;
    @(negedge clk);
    chk(slot_o == 0 && bit_o == 0 && frame_start_o, "R4 resync to frame start", slot_o, 0);
    @(negedge clk);
    fp_in = 1'b1;
    // R4: in-phase edge coincides with the natural wrap
    wait_pos(511);
    fp_in = 1'b0;
    @(negedge clk);
    chk(frame_start_o == 1, "R4 in-phase wrap", frame_start_o, 1);
    @(negedge clk);
    fp_in = 1'b1;
    // R3: four low samples keep the format
    wait_pos(300);
    fp_in = 1'b0;
    repeat (4) @(negedge clk);
    fp_in = 1'b1;
    wait_pos(80);
    chk(fp_o == 1, "R3 four samples keep format", fp_o, 1);
    // R3: five low samples flip to the active-high format
    wait_pos(300);
    fp_in = 1'b0;
    repeat (6) @(negedge clk);
    chk(fp_o == 1, "R3 flip to active-high idle", fp_o, 1);
    // R5: out-of-phase rising edge lands on slot 5
    wait_pos(40);
    fp_in = 1'b1;
    @(negedge clk);
    chk(slot_o == 5 && bit_o == 0, "R5 resync to slot 5", slot_o, 5);
    @(negedge clk);
    chk(slot_o == 5 && bit_o == 1, "R5 second sample no reload", bit_o, 1);
    fp_in = 1'b0;
    // R5: in-phase rising edge
    wait_pos(80);
    fp_in = 1'b1;
    @(negedge clk);
    chk(slot_o == 5 && bit_o == 0, "R5 in-phase", slot_o, 5);
    @(negedge clk);
    fp_in = 1'b0;
    // R8: active-low output straddles the boundary
    wait_pos(510);
    chk(fp_o == 1, "R8 before boundary", fp_o, 1);
    wait_pos(511);
    chk(fp_o == 0, "R8 last half-bit", fp_o, 0);
    wait_pos(0);
    chk(fp_o == 0, "R8 first half-bit", fp_o, 0);
    wait_pos(1);
    chk(fp_o == 1, "R8 after boundary", fp_o, 1);
    repeat (600) @(negedge clk);
    finish_run();
  end
endmodule